// File: doc/BRIEF.md
# Baud-framed serial control word receiver

This block takes a control word that a host signal processor sends bit by bit on one data line. It recovers the bits using a fast sampling clock that runs at 48 times the symbol rate. A slower baud clock, which has no fixed phase relation to the sampling clock, marks the start of each frame with its falling edge. The block brings the baud clock into the sampling domain, counts the 48 slots of each frame, and shifts in the 16 live bits, most significant first. It ignores the other 32 slots.

Once the final live bit is in, the word is decoded. The block produces a signed line level for the pulse-shaping stage, a transmit-enable flag, a receive gain code and a loopback flag. Each frame gives one decoded symbol, marked by a one-cycle valid strobe. The output has no ready signal and cannot be held back: the consumer must take every strobe, because the next word arrives 48 cycles later whatever the consumer does. A baud edge that comes too early, or does not come when due, raises a one-cycle framing-error pulse.

Top module: `baud_word_rx`

## Requirements
- R1: While reset is held and after it is released, before any word completes: sym_valid_o, frame_err_o, tx_en_o and loop_o are 0, sym_level_o is 0 and gain_code_o is 000.
- R2: A falling edge of baud_i sampled before rising clock edge k makes the data sampled at edge k+2 bit 15 of the word. The following 15 rising edges supply bits 14 down to 0, in that order.
- R3: When bit 15 is 1, bits 14:13 set sym_level_o as follows: 00 gives -3 (101), 01 gives -1 (111), 11 gives +1 (001) and 10 gives +3 (011), as 3-bit two's complement.
- R4: When bit 15 is 0, sym_level_o is 0 and tx_en_o is 0, whatever bits 14:13 hold.
- R5: Bits 12:10 are the gain code, in 3 dB steps from 000 (0 dB) to 110 (18 dB), and appear on gain_code_o. The reserved code 111 leaves gain_code_o at its previous value.
- R6: Bit 9 appears on loop_o: 1 selects loopback and 0 selects normal operation.
- R7: Bits 8:0 of the word and the data in slots 16 to 47 of every frame have no effect on any output.
- R8: sym_valid_o is high for exactly one cycle, right after the edge that samples bit 0. sym_level_o, tx_en_o, gain_code_o and loop_o change only at that edge, and all of them change together.
- R9: A frame of 48 slots that ends with no baud falling edge gives a one-cycle frame_err_o pulse after the edge where slot 0 was due. Capture then stops until the next baud falling edge, and no strobe is given.
- R10: A baud falling edge that arrives before slot 0 of an active frame gives a one-cycle frame_err_o pulse. The partly received word is discarded, and a new word is captured starting from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 48 times the symbol rate |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| baud_i | input | 1 | Baud clock, asynchronous; its falling edge marks the start of a frame |
| sdata_i | input | 1 | Serial data, sampled on the rising edge of clk |
| sym_valid_o | output | 1 | One-cycle strobe for a decoded word |
| sym_level_o | output | 3 | Signed line level: -3, -1, 0, +1 or +3 |
| tx_en_o | output | 1 | Decoded transmit enable |
| gain_code_o | output | 3 | Receive gain code, 3 dB per step |
| loop_o | output | 1 | Loopback select |
| frame_err_o | output | 1 | One-cycle pulse for a missing or early baud edge |

## Verification
A baud fall presented before rising edge k takes two synchroniser stages and one edge-detect register to reach the counter. Bit 15 is therefore sampled at edge k+2 and bit 0 at edge k+17. The decoded outputs and the strobe appear after edge k+17. A framing error appears one edge after the slot in which it is detected, so a missing edge shows after edge k+50 of the last good frame. The bench drives and samples on falling clock edges, counted from the falling edge at which baud_i was lowered. It reads the outputs one slot before bit 0 is sampled, in the slot right after the strobe, and in the slot after it, so it can confirm both that nothing changed early and that the strobe lasts one cycle.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

  typedef logic signed [2:0] level_t;

  typedef struct packed {
    logic       en;
    logic [1:0] sym;
    logic [2:0] gain;
    logic       loop;
  } ctrl_t;

  localparam logic [2:0] GAIN_RESERVED = 3'b111;

  // Gray-style four-level mapping; the bit order is fixed by the line code
  function automatic level_t map_symbol(input logic [1:0] s);
    level_t r;
    unique case (s)
      2'b00:   r = -3'sd3;
      2'b01:   r = -3'sd1;
      2'b11:   r = 3'sd1;
      default: r = 3'sd3;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bwr_baud_sync.sv
module bwr_baud_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_i,
  output logic fall_o
);
  // chain[0..STAGES-1]: synchroniser, chain[STAGES]: edge-detect history
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], baud_i};
  end

  assign fall_o = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/bwr_slot_ctr.sv
module bwr_slot_ctr #(
  parameter int SLOTS = 48,
  parameter int LIVE  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  output logic take_o,
  output logic last_o,
  output logic err_o
);
  localparam int PW = $clog2(SLOTS);
  localparam logic [PW-1:0] LAST_SLOT = PW'(SLOTS - 1);
  localparam logic [PW-1:0] LAST_LIVE = PW'(LIVE - 1);
  localparam logic [PW-1:0] LIVE_END  = PW'(LIVE);

  logic [PW-1:0] pos;      // slot index of the next sample
  logic          locked;
  logic          miss, early;

  assign miss   = locked && !fall_i && (pos == '0);
  assign early  = locked && fall_i && (pos != '0);
  assign take_o = fall_i || (locked && (pos != '0) && (pos < LIVE_END));
  assign last_o = !fall_i && locked && (pos == LAST_LIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      locked <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      err_o <= miss | early;
      if (fall_i) begin
        pos    <= PW'(1);
        locked <= 1'b1;
      end else if (miss) begin
        pos    <= '0;
        locked <= 1'b0;
      end else if (locked) begin
        pos <= (pos == LAST_SLOT) ? '0 : pos + PW'(1);
      end
    end
  end

endmodule

// File: rtl/bwr_shift.sv
module bwr_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_i,
  input  logic         d_i,
  output logic [W-1:0] word_o
);
  logic [W-2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)      sh <= '0;
    else if (take_i) sh <= {sh[W-3:0], d_i};
  end

  // word as it stands once the bit now on the line is included
  assign word_o = {sh, d_i};

endmodule

// File: rtl/baud_word_rx.sv
module baud_word_rx
  import bwr_pkg::*;
#(
  parameter int FRAME_SLOTS = 48,
  parameter int WORD_BITS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_i,
  input  logic       sdata_i,
  output logic       sym_valid_o,
  output logic [2:0] sym_level_o,
  output logic       tx_en_o,
  output logic [2:0] gain_code_o,
  output logic       loop_o,
  output logic       frame_err_o
);
  localparam int CTRL_BITS = $bits(ctrl_t);
  localparam int CTRL_LO   = WORD_BITS - CTRL_BITS;

  logic                 fall, take, last;
  logic [WORD_BITS-1:0] word;
  ctrl_t                ctrl;

  bwr_baud_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .baud_i(baud_i), .fall_o(fall)
  );

  bwr_slot_ctr #(.SLOTS(FRAME_SLOTS), .LIVE(WORD_BITS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .fall_i(fall),
    .take_o(take), .last_o(last), .err_o(frame_err_o)
  );

  bwr_shift #(.W(WORD_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .take_i(take), .d_i(sdata_i), .word_o(word)
  );

  // control fields sit at the top of the word; the spare bits below are dropped
  assign ctrl = ctrl_t'(word[WORD_BITS-1:CTRL_LO]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_valid_o <= 1'b0;
      sym_level_o <= '0;
      tx_en_o     <= 1'b0;
      gain_code_o <= '0;
      loop_o      <= 1'b0;
    end else begin
      sym_valid_o <= last;
      if (last) begin
        tx_en_o     <= ctrl.en;
        sym_level_o <= ctrl.en ? map_symbol(ctrl.sym) : '0;
        loop_o      <= ctrl.loop;
        if (ctrl.gain != GAIN_RESERVED) gain_code_o <= ctrl.gain;
      end
    end
  end

endmodule

// File: rtl/bwr_checks.sv
module bwr_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_valid_o,
  input logic [2:0] sym_level_o,
  input logic       tx_en_o,
  input logic [2:0] gain_code_o,
  input logic       loop_o,
  input logic       frame_err_o
);

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |=> !sym_valid_o);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid_o |-> ($stable(sym_level_o) && $stable(tx_en_o)
                      && $stable(gain_code_o) && $stable(loop_o)));

  a_r4_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_o |-> (sym_level_o == 3'b000));

  a_r3_legal_level: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> (sym_level_o == 3'b101 || sym_level_o == 3'b111
                 || sym_level_o == 3'b001 || sym_level_o == 3'b011));

  a_r5_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code_o != 3'b111);

  a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> !sym_valid_o);

  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);

endmodule

bind baud_word_rx bwr_checks u_checks (
  .clk(clk), .rst_n(rst_n), .sym_valid_o(sym_valid_o),
  .sym_level_o(sym_level_o), .tx_en_o(tx_en_o), .gain_code_o(gain_code_o),
  .loop_o(loop_o), .frame_err_o(frame_err_o)
);

// File: tb/tb_baud_word_rx.sv
`timescale 1ns/1ps
module tb_baud_word_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud = 1'b1;
  logic       sdata = 1'b0;
  logic       valid, en, loop, err;
  logic [2:0] level, gain;

  int checks = 0;
  int fails  = 0;

  // model of the registered outputs
  logic [2:0] m_level = 3'b000;
  logic       m_en = 1'b0, m_loop = 1'b0;
  logic [2:0] m_gain = 3'b000;

  always #2.5 clk = ~clk;

  baud_word_rx dut (
    .clk(clk), .rst_n(rst_n), .baud_i(baud), .sdata_i(sdata),
    .sym_valid_o(valid), .sym_level_o(level), .tx_en_o(en),
    .gain_code_o(gain), .loop_o(loop), .frame_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_level(input logic [15:0] w);
    if (!w[15]) return 3'b000;
    case (w[14:13])
      2'b00:   return 3'b101;
      2'b01:   return 3'b111;
      2'b11:   return 3'b001;
      default: return 3'b011;
    endcase
  endfunction

  task automatic chk_model(input string req);
    chk(level == m_level, {req, " level"}, int'(level), int'(m_level));
    chk(en == m_en,       {req, " enable"}, int'(en), int'(m_en));
    chk(gain == m_gain,   {req, " gain"}, int'(gain), int'(m_gain));
    chk(loop == m_loop,   {req, " loop"}, int'(loop), int'(m_loop));
  endtask

  // One frame of len slots; c counts falling edges from the baud fall.
  task automatic run_frame(input logic [15:0] w, input int len, input bit exp_err,
                           input string req);
    int hi_at = (len > 24) ? 24 : len / 2;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (c == 0) baud = 1'b0;
      if (c == hi_at) baud = 1'b1;
      if (c == 3) chk(err == exp_err, "R9 R10 frame error", int'(err), int'(exp_err));
      if (c == 17) begin
        chk(valid == 1'b0, "R8 no early strobe", int'(valid), 0);
        chk_model("R8 before bit 0");
      end
      if (c == 18) begin
        m_en    = w[15];
        m_level = exp_level(w);
        m_loop  = w[9];
        if (w[12:10] != 3'b111) m_gain = w[12:10];
        chk(valid == 1'b1, "R8 strobe", int'(valid), 1);
        chk(err == 1'b0, "R9 no error", int'(err), 0);
        chk_model({req, " R2"});
      end
      if (c == 19) chk(valid == 1'b0, "R8 strobe width", int'(valid), 0);
      sdata = (c >= 2 && c < 18) ? w[17-c] : (c[0] ^ c[2]);
    end
  endtask

  task automatic idle_frame(input bit exp_err);
    for (int c = 0; c < 48; c++) begin
      @(negedge clk);
      if (c == 3) chk(err == exp_err, "R9 missing edge", int'(err), int'(exp_err));
      if (c == 18) chk(valid == 1'b0, "R9 no strobe", int'(valid), 0);
      sdata = c[1];
    end
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(valid == 0 && err == 0, "R1 strobes", int'({valid, err}), 0);
    chk_model("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid == 0 && err == 0, "R1 after release", int'({valid, err}), 0);
    chk_model("R1 released");
  endtask

  task automatic t_symbols();
    run_frame(16'b1_00_000_1_101010101, 48, 1'b0, "R3 sym00");
    run_frame(16'b1_01_001_0_011001100, 48, 1'b0, "R3 sym01");
    run_frame(16'b1_11_010_1_111111111, 48, 1'b0, "R3 sym11");
    run_frame(16'b1_10_011_0_000000000, 48, 1'b0, "R3 sym10");
  endtask

  task automatic t_disable();
    run_frame(16'b0_10_001_0_110110110, 48, 1'b0, "R4 off sym10");
    run_frame(16'b0_00_001_0_000000001, 48, 1'b0, "R4 off sym00");
  endtask

  task automatic t_gain();
    run_frame(16'b1_11_100_0_000000000, 48, 1'b0, "R5 g100");
    run_frame(16'b1_11_101_0_000000000, 48, 1'b0, "R5 g101");
    run_frame(16'b1_11_110_0_000000000, 48, 1'b0, "R5 g110");
    run_frame(16'b1_01_111_0_000000000, 48, 1'b0, "R5 reserved holds");
  endtask

  task automatic t_loop();
    run_frame(16'b1_00_010_1_000000000, 48, 1'b0, "R6 loop on");
    run_frame(16'b1_00_010_0_000000000, 48, 1'b0, "R6 loop off");
  endtask

  task automatic t_spare();
    // R7: only spare bits and slots 16..47 differ; outputs must not move
    run_frame(16'b1_10_011_1_000000000, 48, 1'b0, "R7 spare zero");
    run_frame(16'b1_10_011_1_111111111, 48, 1'b0, "R7 spare ones");
  endtask

  task automatic t_missing();
    idle_frame(1'b1);
    run_frame(16'b1_01_000_1_000000000, 48, 1'b0, "R9 recovered");
  endtask

  task automatic t_early();
    run_frame(16'b0_11_110_0_000000000, 12, 1'b0, "R10 partial");
    run_frame(16'b1_11_001_1_010101010, 48, 1'b1, "R10 restarted");
  endtask

  initial begin
    t_reset();
    t_symbols();
    t_disable();
    t_gain();
    t_loop();
    t_spare();
    t_missing();
    t_early();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule